// File: doc/BRIEF.md
# Event Timer with One-Shot and Periodic Comparators

This block is a register-mapped event timer. A single 64-bit main counter advances by one on every clock while a global enable is set. A small, parameterised set of comparators watches that counter. Each comparator raises a status bit and drives an interrupt line when the counter equals its match value. Software reaches every register over a 32-bit single-cycle bus: writes commit on the clock edge and reads return data in the same cycle.

A comparator runs in one of two modes. In one-shot mode it fires once at its programmed match value. In periodic mode it keeps a hidden period register and adds it to the match value after each hit, so interrupts repeat without software help. The first match time and the period are both loaded through the single compare register by a two-write sequence that a self-clearing value-set bit starts. Software therefore never has to rewrite the shared counter. A comparator can compare the low 32 bits only. Its interrupt is either a level that follows its status bit or a one-cycle pulse per match.

Top module: `evt_timer`

## Requirements
- R1: The main counter holds its value while the global enable (bit 0 of the global config word, byte address 0x010) is 0, and increments by one per clock while it is 1. Software writes its low half (0x030) and its high half (0x034) directly, and a write replaces the increment for that cycle.
- R2: The low capability word (0x000) reads the comparator count minus one in bits [4:0] and a 1 in bit 8 for a 64-bit counter. The high capability word (0x004) reads the tick period in femtoseconds.
- R3: Comparator i has a config word at 0x100+0x20*i with these bits: 0 level interrupt (1 level, 0 pulse), 1 interrupt enable, 2 periodic (1) or one-shot (0), 3 periodic-capable (read-only), 4 value-set, 5 low-32-bit match. On a comparator that is not periodic-capable, the periodic bit and the capable bit both read 0.
- R4: In one-shot mode the status bit of comparator i (bit i of 0x020) becomes 1 in the cycle after the counter equals the match value, and the match value is not changed.
- R5: The compare value is written at offsets +0x08 (low) and +0x0C (high). When value-set is 1, the next compare write loads the match value and clears value-set. In periodic mode, a later compare write loads the period and leaves the match value unchanged.
- R6: In periodic mode, each match adds the period to the match value, so matches repeat one period apart.
- R7: Writing 1 to a bit of the status word clears that bit. Writing 0 leaves the bit unchanged.
- R8: With bit 5 set, only the low 32 bits of the counter take part in the match, and a low-half compare write alone commits the value.
- R9: With interrupt enable 0, a match still sets the status bit, but the interrupt line stays 0.
- R10: In level mode, irq[i] equals status bit i while interrupt enable is 1. In pulse mode, irq[i] is 1 for exactly the one cycle after each match.
- R11: Without bit 5, a low-half compare write is held internally and does not change the compare value until the high-half write commits both halves.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 11 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle while bus_sel is 1 |
| irq | output | NUM_CMP | One interrupt line per comparator |

## Verification
The bench builds the block with three comparators, with only comparators 0 and 1 periodic-capable (PER_CAP = 3'b011), and a tick period of 100000 fs. Comparator 2 is built without periodic support, which lets the bench check the read-only capable bit and the dropped type bit against two comparators that do have it. With three comparators, one-shot, periodic, pulse, low-32-bit and disabled-interrupt behaviour can run side by side. This shows that each status bit sits at its own index. The counter is preset to just below a 32-bit boundary and to a value above 2^32, so the carry into the high half and the low-32-bit match are both reached within a few cycles.

// File: rtl/evt_pkg.sv
// Shared constants and types of the event timer.
// Assumes a 32-bit register bus and a 64-bit main counter.
package evt_pkg;
    localparam int CNT_W  = 64;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 11;

    // Global register byte addresses
    localparam logic [ADDR_W-1:0] A_CAP_LO = 11'h000;
    localparam logic [ADDR_W-1:0] A_CAP_HI = 11'h004;
    localparam logic [ADDR_W-1:0] A_GCFG   = 11'h010;
    localparam logic [ADDR_W-1:0] A_STAT   = 11'h020;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 11'h030;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 11'h034;

    // Comparator register window
    localparam int CMP_BASE   = 'h100;
    localparam int CMP_STRIDE = 'h20;
    localparam int OFF_CFG    = 'h00;
    localparam int OFF_CMP_LO = 'h08;
    localparam int OFF_CMP_HI = 'h0C;

    // Comparator config bit positions
    localparam int CB_LEVEL    = 0;
    localparam int CB_IEN      = 1;
    localparam int CB_PERIODIC = 2;
    localparam int CB_PERCAP   = 3;
    localparam int CB_VALSET   = 4;
    localparam int CB_F32      = 5;

    typedef struct packed {
        logic f32;
        logic valset;
        logic periodic;
        logic ien;
        logic level;
    } cmp_cfg_t;

    // Byte address of a register of comparator idx
    function automatic logic [ADDR_W-1:0] cmp_addr(input int idx, input int off);
        return ADDR_W'(CMP_BASE + CMP_STRIDE * idx + off);
    endfunction
endpackage

// File: rtl/evt_counter.sv
// Free-running main counter of the event timer.
// Counts one per clock while en is high; each bus half-write replaces
// the increment for that cycle. Assumes CNT_W = 2 * BUS_W.
module evt_counter
    import evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [BUS_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt
);
    // Counter register: half writes take priority over counting
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (wr_lo) cnt[BUS_W-1:0] <= wdata;
        else if (wr_hi) cnt[CNT_W-1:BUS_W] <= wdata;
        else if (en)    cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/evt_comparator.sv
// One comparator of the event timer.
// Holds config, the match value (accumulator) and, when periodic-capable,
// a period that is added on each match. Compare writes commit on the high
// half unless low-32-bit mode is set, where the low half commits alone.
// Assumes tick is the counter enable, so matches happen only on counting cycles.
module evt_comparator
    import evt_pkg::*;
#(
    parameter bit PERIODIC_OK = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cfg_we,
    input  logic             lo_we,
    input  logic             hi_we,
    input  logic [BUS_W-1:0] wdata,
    input  logic             st_bit,
    output logic [BUS_W-1:0] cfg_word,
    output logic [CNT_W-1:0] cmp_word,
    output logic             hit,
    output logic             irq
);
    localparam int HI_W = CNT_W - BUS_W;

    cmp_cfg_t         cfg_q;
    logic [CNT_W-1:0] acc_q;
    logic [CNT_W-1:0] per_q;
    logic [BUS_W-1:0] lo_hold_q;
    logic             pulse_q;
    logic             commit;
    logic [CNT_W-1:0] wval;
    logic [CNT_W-1:0] cmp_cnt;
    logic [CNT_W-1:0] reload;

    // Write commit, compare width selection and next periodic match value
    always_comb begin
        commit  = cfg_q.f32 ? lo_we : hi_we;
        wval    = cfg_q.f32 ? {{HI_W{1'b0}}, wdata} : {wdata, lo_hold_q};
        cmp_cnt = cfg_q.f32 ? {{HI_W{1'b0}}, cnt[BUS_W-1:0]} : cnt;
        reload  = cfg_q.f32 ? {{HI_W{1'b0}}, acc_q[BUS_W-1:0] + per_q[BUS_W-1:0]}
                            : acc_q + per_q;
        hit     = tick && (cmp_cnt == acc_q);
    end

    // Config register; value-set clears once a compare write consumes it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            cfg_q.level    <= wdata[CB_LEVEL];
            cfg_q.ien      <= wdata[CB_IEN];
            cfg_q.periodic <= wdata[CB_PERIODIC] & PERIODIC_OK;
            cfg_q.valset   <= wdata[CB_VALSET];
            cfg_q.f32      <= wdata[CB_F32];
        end else if (commit && cfg_q.valset) begin
            cfg_q.valset <= 1'b0;
        end
    end

    // Match value: loaded by a first or one-shot write, advanced on periodic hits
    always_ff @(posedge clk) begin
        if (!rst_n)                                 acc_q <= '0;
        else if (commit && (cfg_q.valset || !cfg_q.periodic)) acc_q <= wval;
        else if (hit && cfg_q.periodic)             acc_q <= reload;
    end

    // Period register: loaded by a compare write in periodic mode without value-set
    always_ff @(posedge clk) begin
        if (!rst_n)                                          per_q <= '0;
        else if (commit && !cfg_q.valset && cfg_q.periodic) per_q <= wval;
    end

    // Holding register for the low half of a 64-bit compare write
    always_ff @(posedge clk) begin
        if (!rst_n)     lo_hold_q <= '0;
        else if (lo_we) lo_hold_q <= wdata;
    end

    // One-cycle interrupt pulse for pulse mode
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= hit && cfg_q.ien && !cfg_q.level;
    end

    // Read-back words and interrupt line
    always_comb begin
        cfg_word              = '0;
        cfg_word[CB_LEVEL]    = cfg_q.level;
        cfg_word[CB_IEN]      = cfg_q.ien;
        cfg_word[CB_PERIODIC] = cfg_q.periodic;
        cfg_word[CB_PERCAP]   = PERIODIC_OK;
        cfg_word[CB_VALSET]   = cfg_q.valset;
        cfg_word[CB_F32]      = cfg_q.f32;
        cmp_word              = acc_q;
        irq = cfg_q.level ? (st_bit && cfg_q.ien) : pulse_q;
    end
endmodule

// File: rtl/evt_timer.sv
// Top of the event timer: register decode, global enable, W1C status
// word, shared main counter and NUM_CMP comparators.
// Assumes single-cycle bus access, NUM_CMP between 1 and 32.
module evt_timer
    import evt_pkg::*;
#(
    parameter int                   NUM_CMP = 3,
    parameter logic [NUM_CMP-1:0]   PER_CAP = 3'b011,
    parameter logic [BUS_W-1:0]     TICK_FS = 32'd100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [NUM_CMP-1:0] irq
);
    logic               wr_en;
    logic               glb_en;
    logic [NUM_CMP-1:0] status_q;
    logic [NUM_CMP-1:0] hit_vec;
    logic [NUM_CMP-1:0] st_clr;
    logic [CNT_W-1:0]   cnt_q;
    logic [BUS_W-1:0]   cap_lo;
    logic [BUS_W-1:0]   rd;
    logic [BUS_W-1:0]   cfg_words [NUM_CMP];
    logic [CNT_W-1:0]   cmp_words [NUM_CMP];

    // Write strobe, status clear mask and capability word
    always_comb begin
        wr_en     = bus_sel && bus_wr;
        st_clr    = (wr_en && bus_addr == A_STAT) ? bus_wdata[NUM_CMP-1:0] : '0;
        cap_lo    = '0;
        cap_lo[4:0] = 5'(NUM_CMP - 1);
        cap_lo[8] = 1'b1;
    end

    // Global enable register
    always_ff @(posedge clk) begin
        if (!rst_n)                          glb_en <= 1'b0;
        else if (wr_en && bus_addr == A_GCFG) glb_en <= bus_wdata[0];
    end

    // Status word: matches set bits, writing ones clears, a match wins
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~st_clr) | hit_vec;
    end

    evt_counter u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (glb_en),
        .wr_lo (wr_en && bus_addr == A_CNT_LO),
        .wr_hi (wr_en && bus_addr == A_CNT_HI),
        .wdata (bus_wdata),
        .cnt   (cnt_q)
    );

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        evt_comparator #(.PERIODIC_OK(PER_CAP[g])) u_cmp (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (glb_en),
            .cnt      (cnt_q),
            .cfg_we   (wr_en && bus_addr == cmp_addr(g, OFF_CFG)),
            .lo_we    (wr_en && bus_addr == cmp_addr(g, OFF_CMP_LO)),
            .hi_we    (wr_en && bus_addr == cmp_addr(g, OFF_CMP_HI)),
            .wdata    (bus_wdata),
            .st_bit   (status_q[g]),
            .cfg_word (cfg_words[g]),
            .cmp_word (cmp_words[g]),
            .hit      (hit_vec[g]),
            .irq      (irq[g])
        );
    end

    // Read multiplexer
    always_comb begin
        case (bus_addr)
            A_CAP_LO: rd = cap_lo;
            A_CAP_HI: rd = TICK_FS;
            A_GCFG:   rd = {{(BUS_W-1){1'b0}}, glb_en};
            A_STAT:   rd = BUS_W'(status_q);
            A_CNT_LO: rd = cnt_q[BUS_W-1:0];
            A_CNT_HI: rd = cnt_q[CNT_W-1:BUS_W];
            default:  rd = '0;
        endcase
        for (int i = 0; i < NUM_CMP; i++) begin
            if (bus_addr == cmp_addr(i, OFF_CFG))    rd = cfg_words[i];
            if (bus_addr == cmp_addr(i, OFF_CMP_LO)) rd = cmp_words[i][BUS_W-1:0];
            if (bus_addr == cmp_addr(i, OFF_CMP_HI)) rd = cmp_words[i][CNT_W-1:BUS_W];
        end
        bus_rdata = bus_sel ? rd : '0;
    end
endmodule

// File: rtl/evt_timer_chk.sv
// Checker for the event timer, bound to every evt_timer instance.
// Watches the bus, the counter, the status word and the match vector.
module evt_timer_chk
    import evt_pkg::*;
#(
    parameter int NUM_CMP = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [BUS_W-1:0]   bus_wdata,
    input logic [NUM_CMP-1:0] irq,
    input logic [CNT_W-1:0]   cnt_q,
    input logic               glb_en,
    input logic [NUM_CMP-1:0] status_q,
    input logic [NUM_CMP-1:0] hit_vec
);
    logic               cnt_wr;
    logic               st_wr;
    logic [NUM_CMP-1:0] wmask;

    // Bus event decode for the properties
    always_comb begin
        cnt_wr = bus_sel && bus_wr && (bus_addr == A_CNT_LO || bus_addr == A_CNT_HI);
        st_wr  = bus_sel && bus_wr && (bus_addr == A_STAT);
        wmask  = bus_wdata[NUM_CMP-1:0];
    end

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_en && !cnt_wr) |=> $stable(cnt_q)); // R1
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_en && !cnt_wr) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R1
    AST_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit_vec) |=> ((status_q & $past(hit_vec)) == $past(hit_vec))); // R4
    AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && ((hit_vec & wmask) == '0)) |=> ((status_q & $past(wmask)) == '0)); // R7
    AST_ZERO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr |=> ((status_q & $past(status_q & ~wmask)) == $past(status_q & ~wmask))); // R7
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((irq & ~status_q & ~$past(hit_vec)) == '0)); // R10
endmodule

bind evt_timer evt_timer_chk #(.NUM_CMP(NUM_CMP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .cnt_q     (cnt_q),
    .glb_en    (glb_en),
    .status_q  (status_q),
    .hit_vec   (hit_vec)
);

// File: tb/evt_timer_bench.sv
// Directed bench for evt_timer: one task per scenario, each checking itself.
module evt_timer_bench;
    import evt_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NCMP = 3;
    localparam logic [31:0] TFS = 32'd100000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NCMP-1:0]   irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    evt_timer #(.NUM_CMP(NCMP), .PER_CAP(3'b011), .TICK_FS(TFS)) u_evt_timer (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Step until the counter low half reads t
    task automatic wait_lo(input logic [31:0] t, input string req);
        logic [31:0] v;
        bit found = 1'b0;
        for (int k = 0; k < 2000; k++) begin
            bus_read(A_CNT_LO, v);
            if (v == t) begin found = 1'b1; break; end
            step();
        end
        chk({req, " counter reaches target"}, {31'b0, found}, 32'd1);
    endtask

    task automatic restart();
        bus_write(A_GCFG, 32'd0);
        bus_write(A_CNT_LO, 32'd0);
        bus_write(A_CNT_HI, 32'd0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        bus_read(A_CNT_LO, v);  chk("R1 reset counter", v, 32'd0);
        bus_read(A_STAT, v);    chk("R7 reset status", v, 32'd0);
        bus_read(cmp_addr(0, OFF_CFG), v); chk("R3 reset cfg0 capable", v, 32'h08);
        bus_read(cmp_addr(2, OFF_CFG), v); chk("R3 reset cfg2 not capable", v, 32'h00);
        chk("R10 reset irq", {29'b0, irq}, 32'd0);
    endtask

    task automatic t_cap();
        logic [31:0] v;
        bus_read(A_CAP_LO, v); chk("R2 capability low", v, 32'h102);
        bus_read(A_CAP_HI, v); chk("R2 capability high", v, TFS);
    endtask

    task automatic t_cfg_bits();
        logic [31:0] v;
        bus_write(cmp_addr(2, OFF_CFG), 32'h07);
        bus_read(cmp_addr(2, OFF_CFG), v); chk("R3 type bit dropped", v, 32'h03);
        bus_write(cmp_addr(0, OFF_CFG), 32'h07);
        bus_read(cmp_addr(0, OFF_CFG), v); chk("R3 type bit kept", v, 32'h0F);
        bus_write(cmp_addr(0, OFF_CFG), 32'h00);
        bus_write(cmp_addr(2, OFF_CFG), 32'h00);
    endtask

    task automatic t_counter();
        logic [31:0] v0, v1;
        for (int k = 0; k < 5; k++) step();
        bus_read(A_CNT_LO, v0); chk("R1 disabled counter holds", v0, 32'd0);
        bus_write(A_CNT_LO, 32'hFFFF_FFFE);
        bus_write(A_CNT_HI, 32'd7);
        bus_read(A_CNT_LO, v0); chk("R1 low half write", v0, 32'hFFFF_FFFE);
        bus_read(A_CNT_HI, v0); chk("R1 high half write", v0, 32'd7);
        bus_write(A_GCFG, 32'd1);
        wait_lo(32'd1, "R1");
        bus_read(A_CNT_HI, v0); chk("R1 carry into high half", v0, 32'd8);
        bus_write(A_GCFG, 32'd0);
        bus_read(A_CNT_LO, v0);
        for (int k = 0; k < 5; k++) step();
        bus_read(A_CNT_LO, v1); chk("R1 stops when disabled", v1, v0);
    endtask

    task automatic t_oneshot();
        logic [31:0] v;
        restart();
        bus_write(cmp_addr(0, OFF_CFG), 32'h03);
        bus_write(cmp_addr(0, OFF_CMP_LO), 32'd40);
        bus_read(cmp_addr(0, OFF_CMP_LO), v); chk("R11 low half held", v, 32'd0);
        bus_write(cmp_addr(0, OFF_CMP_HI), 32'd0);
        bus_read(cmp_addr(0, OFF_CMP_LO), v); chk("R11 committed on high", v, 32'd40);
        bus_write(A_STAT, 32'h7);
        bus_write(A_GCFG, 32'd1);
        wait_lo(32'd40, "R4");
        bus_read(A_STAT, v); chk("R4 no status before match", v & 32'h1, 32'h0);
        chk("R10 level irq low before match", {31'b0, irq[0]}, 32'd0);
        step();
        bus_read(A_STAT, v); chk("R4 status after match", v & 32'h1, 32'h1);
        chk("R10 level irq high", {31'b0, irq[0]}, 32'd1);
        bus_read(cmp_addr(0, OFF_CMP_LO), v); chk("R4 no reload", v, 32'd40);
        for (int k = 0; k < 3; k++) step();
        chk("R10 level irq holds", {31'b0, irq[0]}, 32'd1);
        bus_write(A_STAT, 32'h0);
        bus_read(A_STAT, v); chk("R7 zero write keeps bit", v & 32'h1, 32'h1);
        bus_write(A_STAT, 32'h1);
        bus_read(A_STAT, v); chk("R7 one write clears bit", v & 32'h1, 32'h0);
        chk("R10 level irq follows status", {31'b0, irq[0]}, 32'd0);
    endtask

    task automatic t_periodic();
        logic [31:0] v;
        restart();
        bus_write(cmp_addr(1, OFF_CFG), 32'h16);
        bus_read(cmp_addr(1, OFF_CFG), v); chk("R5 value-set reads set", v, 32'h1E);
        bus_write(cmp_addr(1, OFF_CMP_LO), 32'd20);
        bus_write(cmp_addr(1, OFF_CMP_HI), 32'd0);
        bus_read(cmp_addr(1, OFF_CFG), v); chk("R5 value-set self clears", v, 32'h0E);
        bus_write(cmp_addr(1, OFF_CMP_LO), 32'd10);
        bus_write(cmp_addr(1, OFF_CMP_HI), 32'd0);
        bus_read(cmp_addr(1, OFF_CMP_LO), v); chk("R5 period write keeps match", v, 32'd20);
        bus_write(A_STAT, 32'h7);
        bus_write(A_GCFG, 32'd1);
        wait_lo(32'd20, "R6");
        chk("R10 pulse low before match", {31'b0, irq[1]}, 32'd0);
        step();
        chk("R10 pulse after first match", {31'b0, irq[1]}, 32'd1);
        bus_read(cmp_addr(1, OFF_CMP_LO), v); chk("R6 match advanced by period", v, 32'd30);
        step();
        chk("R10 pulse lasts one cycle", {31'b0, irq[1]}, 32'd0);
        bus_write(A_STAT, 32'h2);
        wait_lo(32'd30, "R6");
        bus_read(A_STAT, v); chk("R6 no status before second match", v & 32'h2, 32'h0);
        step();
        bus_read(A_STAT, v); chk("R6 second match status", v & 32'h2, 32'h2);
        chk("R10 pulse second match", {31'b0, irq[1]}, 32'd1);
        wait_lo(32'd40, "R6");
        step();
        chk("R6 third match pulse", {31'b0, irq[1]}, 32'd1);
        bus_read(cmp_addr(1, OFF_CMP_LO), v); chk("R6 match after three hits", v, 32'd50);
    endtask

    task automatic t_force32();
        logic [31:0] v;
        bus_write(A_GCFG, 32'd0);
        bus_write(A_CNT_LO, 32'd0);
        bus_write(A_CNT_HI, 32'd1);
        bus_write(cmp_addr(0, OFF_CFG), 32'h23);
        bus_write(cmp_addr(0, OFF_CMP_LO), 32'd60);
        bus_read(cmp_addr(0, OFF_CMP_LO), v); chk("R8 low write commits alone", v, 32'd60);
        bus_write(cmp_addr(2, OFF_CFG), 32'h03);
        bus_write(cmp_addr(2, OFF_CMP_LO), 32'd60);
        bus_write(cmp_addr(2, OFF_CMP_HI), 32'd0);
        bus_write(A_STAT, 32'h7);
        bus_write(A_GCFG, 32'd1);
        wait_lo(32'd60, "R8");
        step();
        bus_read(A_STAT, v); chk("R8 low-32 match only", v & 32'h5, 32'h1);
    endtask

    task automatic t_ien_off();
        logic [31:0] v;
        restart();
        bus_write(cmp_addr(0, OFF_CFG), 32'h01);
        bus_write(cmp_addr(0, OFF_CMP_LO), 32'd15);
        bus_write(cmp_addr(0, OFF_CMP_HI), 32'd0);
        bus_write(A_STAT, 32'h7);
        bus_write(A_GCFG, 32'd1);
        wait_lo(32'd15, "R9");
        step();
        bus_read(A_STAT, v); chk("R9 status set while disabled", v & 32'h1, 32'h1);
        chk("R9 irq stays low", {31'b0, irq[0]}, 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cap();
        t_cfg_bits();
        t_counter();
        t_oneshot();
        t_periodic();
        t_force32();
        t_ien_off();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule